// File: doc/BRIEF.md
# MDIO Management Scan Controller

This block is a management-bus master for external Ethernet PHYs. A host gives it parallel commands, and the block handles the two-wire serial bus. The block divides the system clock to make MDC. It shifts out complete frames: 32 preamble ones, a start pattern, an opcode, a 5-bit PHY address, a 5-bit register address, a turnaround and 16 data bits. On reads it captures the PHY's reply. A single command reads or writes one register of one device.

The block holds a 32-entry shadow RAM with one 16-bit word per device. A gang command applies one register access to every device selected by a 32-bit enable mask, in ascending device order:
- A gang read fills each selected device's shadow word.
- A gang write sends each selected device its own shadow word.

Devices that are not selected are skipped at no bus cost.

With scanning switched on, the block reads a chosen register from each enabled device in a continuous round-robin loop. When a reply differs from the stored word, the block stores the new value and sets that device's sticky changed bit. The interrupt output stays high while any changed bit is set. The host clears these bits by writing ones.

Top module: `mdio_scan_ctrl`

## Requirements
- R1: Every frame is 64 MDC periods, sent in this order: 32 ones, start `01`, opcode (`10` read, `01` write), PHY address MSB first, register address MSB first, turnaround (`10` on writes), then 16 data bits MSB first.
- R2: MDC is high for DIV_HALF system clocks and low for DIV_HALF clocks within a frame. `mdio_o` changes only in the clock in which MDC falls.
- R3: On a read frame, `mdio_oe` is low from the first turnaround bit to the end of the frame. The value sampled on the 16 data bits appears on `rd_data` after a single read (`cmd_op`=0).
- R4: Between frames MDC is low and `mdio_oe` is low.
- R5: A single write (`cmd_op`=1) sends `cmd_wdata` to the addressed register of `cmd_phy`.
- R6: A gang read (`cmd_op`=2) reads register `cmd_reg` of each device whose `dev_mask` bit is set, in ascending order, and stores each reply in that device's shadow word. Unselected devices get no frame and keep their words. An empty mask produces no frame.
- R7: A gang write (`cmd_op`=3) sends each selected device its shadow word, and unselected devices get no frame.
- R8: The host reaches shadow word n at `host_addr`=n, which is byte address bits 6:2. `host_rdata[31:16]` reads zero, and `host_we` writes `host_wdata`.
- R9: A command is accepted only in a clock where `busy` is low. A command presented while `busy` is high has no effect.
- R10: With `scan_en` set, the block reads `scan_reg` from the enabled devices round-robin. A reply that differs from the shadow word replaces the word and sets `changed[n]`. An equal reply sets nothing.
- R11: `irq` is high exactly when some `changed` bit is set. Writing a one to `chg_clr[n]` clears `changed[n]` in the next clock.
- R12: When a command is waiting at a frame boundary while scanning, the command's frame is the next frame on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 read, 1 write, 2 gang read, 3 gang write |
| cmd_phy | input | 5 | Device address for single commands |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data for a single write |
| busy | output | 1 | Command, gang run or scan frame in progress |
| rd_data | output | 16 | Result of the last single read |
| dev_mask | input | 32 | Devices taking part in gang and scan |
| scan_en | input | 1 | Continuous scan enable |
| scan_reg | input | 5 | Register polled by the scan |
| host_addr | input | 5 | Shadow word index (byte address bits 6:2) |
| host_we | input | 1 | Shadow write strobe |
| host_wdata | input | 16 | Shadow write data |
| host_rdata | output | 32 | Shadow read data, upper half zero |
| chg_clr | input | 32 | Write-one-to-clear for changed bits |
| changed | output | 32 | Sticky per-device change flags |
| irq | output | 1 | Interrupt, any changed bit set |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data drive enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench models a PHY that decodes every frame bit by bit. Each clock it checks that the line is never driven from both sides, which catches a turnaround released a bit late. It also checks that data moves only on a falling MDC edge; a divider off by one or a launch on the wrong edge fails this. Gang runs use a sparse mask that includes device 0 and device 31. A gang loop that wrapped at 31, stopped early or spent a frame on a skipped device would log the wrong frame count or touch an excluded register. The scan is checked both for a quiet loop with no interrupt and for an injected change. A command is sent while scanning to show that it goes first at the boundary. A command pulsed during a busy period must leave the bus frame count unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int N_DEV      = 32;
    localparam int IDX_W      = $clog2(N_DEV);
    localparam int REG_W      = 5;
    localparam int DW         = 16;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;

    typedef enum logic [1:0] {
        CMD_RD = 2'd0, CMD_WR = 2'd1, CMD_GANG_RD = 2'd2, CMD_GANG_WR = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        K_SRD, K_SWR, K_GRD, K_GWR, K_SCAN
    } kind_e;

    typedef struct packed {
        logic             rd;
        logic [IDX_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic [DW-1:0]    data;
    } frame_req_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // lowest enabled device index at or above 'from'
    function automatic pick_t pick_from(input logic [N_DEV-1:0] mask, input logic [IDX_W:0] from);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (mask[i] && i >= int'(from)) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input frame_req_t r);
        return {32'hFFFF_FFFF, 2'b01, (r.rd ? 2'b10 : 2'b01), r.phy, r.regad,
                2'b10, (r.rd ? 16'hFFFF : r.data)};
    endfunction
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_req_t       req,
    output logic             active,
    output logic             done,
    output logic [DW-1:0]    rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(DIV_HALF - 1);
    localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);
    localparam logic [5:0] TA_BIT   = 6'(TA_POS);
    localparam logic [5:0] DAT_BIT  = 6'(DATA_POS);

    logic                  active_q, mdc_q, o_q, oe_q, rd_q, done_q;
    logic [FRAME_BITS-1:0] shreg, frm;
    logic [5:0]            bit_idx;
    logic [CW-1:0]         div_cnt;
    logic [DW-1:0]         rsh;
    logic                  tick;

    always_comb frm = build_frame(req);
    assign tick = active_q && (div_cnt == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0; mdc_q <= 1'b0; o_q <= 1'b1; oe_q <= 1'b0;
            rd_q <= 1'b0; done_q <= 1'b0; shreg <= '0; bit_idx <= '0;
            div_cnt <= '0; rsh <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                div_cnt <= '0;
                if (start) begin
                    active_q <= 1'b1;
                    o_q      <= frm[FRAME_BITS-1];
                    shreg    <= frm << 1;
                    bit_idx  <= '0;
                    rd_q     <= req.rd;
                    oe_q     <= 1'b1;
                    mdc_q    <= 1'b0;
                end
            end else begin
                div_cnt <= tick ? '0 : div_cnt + CW'(1);
                if (tick) begin
                    if (!mdc_q) begin
                        mdc_q <= 1'b1;
                        if (rd_q && bit_idx >= DAT_BIT) rsh <= {rsh[DW-2:0], mdio_i};
                    end else begin
                        mdc_q <= 1'b0;
                        if (bit_idx == LAST_BIT) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                            oe_q     <= 1'b0;
                            o_q      <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 6'd1;
                            o_q     <= shreg[FRAME_BITS-1];
                            shreg   <= shreg << 1;
                            oe_q    <= !(rd_q && (bit_idx + 6'd1 >= TA_BIT));
                        end
                    end
                end
            end
        end
    end

    assign active  = active_q;
    assign done    = done_q;
    assign rdata   = rsh;
    assign mdc     = mdc_q;
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;

    // R4: bus quiet between frames
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (!oe_q && !mdc_q));
    // R2: data launches only on a falling clock
    p_launch_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (active_q && $past(active_q) && (o_q != $past(o_q))) |-> $fell(mdc_q));
    // R3: line released from turnaround onward on reads
    p_rd_release_r3: assert property (@(posedge clk) disable iff (rst)
        (active_q && rd_q && bit_idx >= TA_BIT) |-> !oe_q);
endmodule

// File: rtl/mdio_shadow.sv
module mdio_shadow
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] host_idx,
    input  logic             host_we,
    input  logic [DW-1:0]    host_wdata,
    output logic [31:0]      host_rdata,
    input  logic [IDX_W-1:0] a_idx,
    output logic [DW-1:0]    a_data,
    input  logic [IDX_W-1:0] b_idx,
    output logic [DW-1:0]    b_data,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [DW-1:0]    eng_wdata,
    input  logic             chg_set,
    input  logic [IDX_W-1:0] chg_idx,
    input  logic [N_DEV-1:0] chg_clr,
    output logic [N_DEV-1:0] changed,
    output logic             irq
);
    logic [DW-1:0] words [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_ent
        logic [DW-1:0] word_q;
        logic          chg_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                chg_q  <= 1'b0;
            end else begin
                if (eng_we && eng_idx == IDX_W'(g))       word_q <= eng_wdata;
                else if (host_we && host_idx == IDX_W'(g)) word_q <= host_wdata;
                if (chg_set && chg_idx == IDX_W'(g))      chg_q <= 1'b1;
                else if (chg_clr[g])                      chg_q <= 1'b0;
            end
        end
        assign words[g]   = word_q;
        assign changed[g] = chg_q;
    end

    assign a_data     = words[a_idx];
    assign b_data     = words[b_idx];
    assign host_rdata = {{(32-DW){1'b0}}, words[host_idx]};
    assign irq        = |changed;

    // R10: a detected change is flagged in the next clock
    p_chg_flag_r10: assert property (@(posedge clk) disable iff (rst)
        chg_set |=> changed[$past(chg_idx)]);
    // R11: full clear with no new change drops the interrupt
    p_clr_all_r11: assert property (@(posedge clk) disable iff (rst)
        (&chg_clr && !chg_set) |=> !irq);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  cmd_e             cmd_op,
    input  logic [IDX_W-1:0] cmd_phy,
    input  logic [REG_W-1:0] cmd_reg,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [N_DEV-1:0] dev_mask,
    input  logic             scan_en,
    input  logic [REG_W-1:0] scan_reg,
    output logic             busy,
    output logic [DW-1:0]    rd_data,
    output logic             eng_start,
    output frame_req_t       eng_req,
    input  logic             eng_done,
    input  logic [DW-1:0]    eng_rdata,
    output logic [IDX_W-1:0] a_idx,
    input  logic [DW-1:0]    a_data,
    output logic [IDX_W-1:0] b_idx,
    input  logic [DW-1:0]    b_data,
    output logic             eng_we,
    output logic [IDX_W-1:0] eng_idx,
    output logic [DW-1:0]    eng_wdata,
    output logic             chg_set,
    output logic [IDX_W-1:0] chg_idx
);
    logic             run_q;
    kind_e            kind_q;
    logic [IDX_W-1:0] cur_q, scan_ptr_q;
    logic [REG_W-1:0] reg_q;
    logic [DW-1:0]    rd_q;
    pick_t            pick_first, pick_next, scan_a, scan_pick;
    logic             gang_q, mismatch;

    assign gang_q = (kind_q == K_GRD) || (kind_q == K_GWR);

    always_comb begin
        pick_first = pick_from(dev_mask, '0);
        pick_next  = pick_from(dev_mask, {1'b0, cur_q} + (IDX_W+1)'(1));
        scan_a     = pick_from(dev_mask, {1'b0, scan_ptr_q});
        scan_pick  = scan_a.hit ? scan_a : pick_first;
    end

    assign a_idx    = cur_q;
    assign b_idx    = run_q ? pick_next.idx : pick_first.idx;
    assign mismatch = run_q && eng_done && (kind_q == K_SCAN) && (eng_rdata != a_data);

    always_comb begin
        eng_start = 1'b0;
        eng_req   = '0;
        if (!run_q) begin
            if (cmd_valid) begin
                eng_req.regad = cmd_reg;
                unique case (cmd_op)
                    CMD_RD: begin
                        eng_start = 1'b1; eng_req.rd = 1'b1; eng_req.phy = cmd_phy;
                    end
                    CMD_WR: begin
                        eng_start = 1'b1; eng_req.phy = cmd_phy; eng_req.data = cmd_wdata;
                    end
                    CMD_GANG_RD: begin
                        eng_start = pick_first.hit; eng_req.rd = 1'b1; eng_req.phy = pick_first.idx;
                    end
                    CMD_GANG_WR: begin
                        eng_start = pick_first.hit; eng_req.phy = pick_first.idx; eng_req.data = b_data;
                    end
                    default: ;
                endcase
            end else if (scan_en && scan_pick.hit) begin
                eng_start     = 1'b1;
                eng_req.rd    = 1'b1;
                eng_req.phy   = scan_pick.idx;
                eng_req.regad = scan_reg;
            end
        end else if (eng_done && gang_q && pick_next.hit) begin
            eng_start     = 1'b1;
            eng_req.rd    = (kind_q == K_GRD);
            eng_req.phy   = pick_next.idx;
            eng_req.regad = reg_q;
            eng_req.data  = b_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0; kind_q <= K_SRD; cur_q <= '0; scan_ptr_q <= '0;
            reg_q <= '0; rd_q <= '0;
        end else if (!run_q) begin
            if (cmd_valid) begin
                reg_q <= cmd_reg;
                run_q <= eng_start;
                unique case (cmd_op)
                    CMD_RD:      begin kind_q <= K_SRD; cur_q <= cmd_phy; end
                    CMD_WR:      begin kind_q <= K_SWR; cur_q <= cmd_phy; end
                    CMD_GANG_RD: begin kind_q <= K_GRD; cur_q <= pick_first.idx; end
                    default:     begin kind_q <= K_GWR; cur_q <= pick_first.idx; end
                endcase
            end else if (eng_start) begin
                run_q  <= 1'b1;
                kind_q <= K_SCAN;
                cur_q  <= scan_pick.idx;
            end
        end else if (eng_done) begin
            if (kind_q == K_SRD) rd_q <= eng_rdata;
            if (kind_q == K_SCAN) scan_ptr_q <= cur_q + 1'b1;
            if (gang_q && pick_next.hit) cur_q <= pick_next.idx;
            else                         run_q <= 1'b0;
        end
    end

    assign busy      = run_q;
    assign rd_data   = rd_q;
    assign eng_we    = run_q && eng_done && ((kind_q == K_GRD) || mismatch);
    assign eng_idx   = cur_q;
    assign eng_wdata = eng_rdata;
    assign chg_set   = mismatch;
    assign chg_idx   = cur_q;

    // R9: a request during a busy period leaves the operation untouched
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && cmd_valid && !eng_done) |=> (kind_q == $past(kind_q)) && (cur_q == $past(cur_q)));
    // R6: gang frames only go to enabled devices
    p_gang_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (run_q && eng_start) |-> dev_mask[eng_req.phy]);
endmodule

// File: rtl/mdio_scan_ctrl.sv
module mdio_scan_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic [15:0] rd_data,
    input  logic [31:0] dev_mask,
    input  logic        scan_en,
    input  logic [4:0]  scan_reg,
    input  logic [4:0]  host_addr,
    input  logic        host_we,
    input  logic [15:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic [31:0] chg_clr,
    output logic [31:0] changed,
    output logic        irq,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             eng_start, eng_active, eng_done, eng_we, chg_set;
    frame_req_t       eng_req;
    logic [DW-1:0]    eng_rdata, a_data, b_data, eng_wdata;
    logic [IDX_W-1:0] a_idx, b_idx, eng_idx, chg_idx;

    mdio_seq u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_e'(cmd_op)),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .dev_mask(dev_mask), .scan_en(scan_en), .scan_reg(scan_reg),
        .busy(busy), .rd_data(rd_data), .eng_start(eng_start), .eng_req(eng_req),
        .eng_done(eng_done), .eng_rdata(eng_rdata), .a_idx(a_idx), .a_data(a_data),
        .b_idx(b_idx), .b_data(b_data), .eng_we(eng_we), .eng_idx(eng_idx),
        .eng_wdata(eng_wdata), .chg_set(chg_set), .chg_idx(chg_idx)
    );

    mdio_frame #(.DIV_HALF(DIV_HALF)) u_frame (
        .clk(clk), .rst(rst), .start(eng_start), .req(eng_req), .active(eng_active),
        .done(eng_done), .rdata(eng_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    mdio_shadow u_shadow (
        .clk(clk), .rst(rst), .host_idx(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .a_idx(a_idx),
        .a_data(a_data), .b_idx(b_idx), .b_data(b_data), .eng_we(eng_we),
        .eng_idx(eng_idx), .eng_wdata(eng_wdata), .chg_set(chg_set),
        .chg_idx(chg_idx), .chg_clr(chg_clr), .changed(changed), .irq(irq)
    );

    // R12: a new frame never starts over one in flight
    p_start_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !eng_active);
endmodule

// File: tb/mdio_scan_ctrl_tb.sv
module mdio_scan_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIVH       = 2;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_phy = '0, cmd_reg = '0, scan_reg = '0, host_addr = '0;
    logic [15:0] cmd_wdata = '0, host_wdata = '0, rd_data;
    logic [31:0] dev_mask = '0, chg_clr = '0, host_rdata, changed;
    logic        busy, scan_en = 1'b0, host_we = 1'b0, irq, mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0, fails = 0;

    mdio_scan_ctrl #(.DIV_HALF(DIVH)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_phy(cmd_phy),
        .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy), .rd_data(rd_data),
        .dev_mask(dev_mask), .scan_en(scan_en), .scan_reg(scan_reg), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .chg_clr(chg_clr), .changed(changed), .irq(irq), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural PHY model ----------------
    logic [15:0] phy_regs [32][32];
    int          pcnt = 0;
    logic [63:0] psh = '0;
    logic        prd = 1'b0, phy_oe = 1'b0, phy_bit = 1'b1;
    logic [4:0]  pphy, preg;
    logic [15:0] pdata;
    int          fr_n = 0;
    logic [1:0]  fr_op   [512];
    logic [4:0]  fr_phy  [512];
    logic [4:0]  fr_reg  [512];
    logic [15:0] fr_data [512];
    wire         line = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);
    assign mdio_i = phy_oe ? phy_bit : 1'b1;

    always @(posedge mdc) begin
        psh = {psh[62:0], line};
        pcnt++;
        if (pcnt == 46) begin
            prd   = (psh[11:10] == 2'b10);
            pphy  = psh[9:5];
            preg  = psh[4:0];
            pdata = phy_regs[pphy][preg];
        end
        if (prd && pcnt >= 47) chk(!mdio_oe, "R3", "oe during read reply", mdio_oe, 0);
        if (pcnt == 64) begin
            chk(psh[63:32] == 32'hFFFF_FFFF, "R1", "preamble", psh[63:32], 32'hFFFF_FFFF);
            chk(psh[31:30] == 2'b01, "R1", "start", psh[31:30], 1);
            if (!prd) chk(psh[17:16] == 2'b10, "R1", "write turnaround", psh[17:16], 2);
            fr_op[fr_n] = psh[29:28]; fr_phy[fr_n] = psh[27:23];
            fr_reg[fr_n] = psh[22:18]; fr_data[fr_n] = psh[15:0];
            if (psh[29:28] == 2'b01) phy_regs[psh[27:23]][psh[22:18]] = psh[15:0];
            fr_n++;
            pcnt = 0;
            prd  = 1'b0;
        end
    end

    always @(negedge mdc) begin
        if (prd && pcnt >= 47 && pcnt <= 63) begin
            phy_oe  = 1'b1;
            phy_bit = (pcnt == 47) ? 1'b0 : pdata[63 - pcnt];
        end else begin
            phy_oe = 1'b0;
        end
    end

    // ---------------- per-clock comparison ----------------
    logic prev_o = 1'b1, prev_mdc = 1'b0;
    int   hi_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            chk(irq == (changed != 0), "R11", "irq vs changed", irq, changed != 0);
            if (mdio_o != prev_o)
                chk(prev_mdc && !mdc, "R2", "mdio_o moved off a falling edge", mdc, 0);
            if (mdio_oe && phy_oe) chk(0, "R3", "bus contention", 1, 0);
            if (mdc) hi_len++;
            else if (prev_mdc) begin
                chk(hi_len == DIVH, "R2", "mdc high length", hi_len, DIVH);
                hi_len = 0;
            end
        end
        prev_o   = mdio_o;
        prev_mdc = mdc;
    end

    // ---------------- host helpers ----------------
    task automatic issue(input logic [1:0] op, input int phy, input int rg, input logic [15:0] d);
        bit sent = 0;
        while (!sent) begin
            @(negedge clk);
            if (!busy) begin
                cmd_op = op; cmd_phy = 5'(phy); cmd_reg = 5'(rg); cmd_wdata = d;
                cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
                sent = 1;
            end
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic wait_frames(input int target);
        while (fr_n < target) @(negedge clk);
    endtask

    task automatic host_wr(input int idx, input logic [15:0] d);
        @(negedge clk);
        host_addr = 5'(idx); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        host_addr = 5'(idx);
        #1 v = host_rdata;
    endtask

    initial begin
        for (int d = 0; d < 32; d++)
            for (int r = 0; r < 32; r++) phy_regs[d][r] = 16'h0000;
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !irq && changed == 0, "R4", "reset state", {busy, irq}, 0);
        chk(!mdc && !mdio_oe, "R4", "reset bus", {mdc, mdio_oe}, 0);

        // R5 / R1: single write
        issue(2'd1, 5, 3, 16'hA5C3);
        wait_idle();
        chk(fr_n == 1 && fr_op[0] == 2'b01, "R1", "write opcode", fr_op[0], 1);
        chk(fr_phy[0] == 5 && fr_reg[0] == 3, "R1", "write address", {fr_phy[0], fr_reg[0]}, {5'd5, 5'd3});
        chk(phy_regs[5][3] == 16'hA5C3, "R5", "write data", phy_regs[5][3], 16'hA5C3);
        chk(!mdc && !mdio_oe, "R4", "idle after frame", {mdc, mdio_oe}, 0);

        // R3: single read
        phy_regs[9][2] = 16'h1234;
        issue(2'd0, 9, 2, 16'h0);
        wait_idle();
        chk(fr_op[1] == 2'b10, "R1", "read opcode", fr_op[1], 2);
        chk(rd_data == 16'h1234, "R3", "single read data", rd_data, 16'h1234);

        // R9: request during busy ignored
        n0 = fr_n;
        issue(2'd0, 1, 1, 16'h0);
        @(negedge clk);
        cmd_op = 2'd1; cmd_phy = 5'd7; cmd_reg = 5'd0; cmd_wdata = 16'hFFFF; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk(fr_n == n0 + 1, "R9", "frames after busy request", fr_n, n0 + 1);
        chk(phy_regs[7][0] == 16'h0, "R9", "ignored write", phy_regs[7][0], 0);

        // R6: gang read over a sparse mask
        for (int d = 0; d < 32; d++) phy_regs[d][4] = 16'h1000 + 16'(d * 3);
        dev_mask = (32'd1 << 0) | (32'd1 << 3) | (32'd1 << 17) | (32'd1 << 31);
        n0 = fr_n;
        issue(2'd2, 0, 4, 16'h0);
        wait_idle();
        chk(fr_n == n0 + 4, "R6", "gang read frame count", fr_n, n0 + 4);
        chk(fr_phy[n0] == 0 && fr_phy[n0 + 3] == 31, "R6", "gang order", {fr_phy[n0], fr_phy[n0+3]}, {5'd0, 5'd31});
        host_rd(17, v);
        chk(v == 32'h0000_1033, "R8", "shadow word 17", v, 32'h1033);
        host_rd(31, v);
        chk(v == 32'h0000_105D, "R6", "shadow word 31", v, 32'h105D);
        host_rd(5, v);
        chk(v == 32'h0, "R6", "unselected shadow word", v, 0);

        // R7: gang write
        host_wr(2, 16'h2222);
        host_wr(31, 16'h3131);
        host_wr(4, 16'h4444);
        host_rd(4, v);
        chk(v == 32'h0000_4444, "R8", "host write readback", v, 32'h4444);
        dev_mask = (32'd1 << 2) | (32'd1 << 31);
        n0 = fr_n;
        issue(2'd3, 0, 6, 16'h0);
        wait_idle();
        chk(fr_n == n0 + 2, "R7", "gang write frame count", fr_n, n0 + 2);
        chk(phy_regs[2][6] == 16'h2222 && phy_regs[31][6] == 16'h3131, "R7", "gang write data",
            {phy_regs[2][6], phy_regs[31][6]}, {16'h2222, 16'h3131});
        chk(phy_regs[4][6] == 16'h0, "R7", "unselected device", phy_regs[4][6], 0);

        // R6: empty mask gang
        dev_mask = '0;
        n0 = fr_n;
        issue(2'd2, 0, 4, 16'h0);
        repeat (20) @(negedge clk);
        chk(fr_n == n0 && !busy, "R6", "empty mask gang", fr_n, n0);

        // R10: quiet scan
        dev_mask = (32'd1 << 3) | (32'd1 << 17);
        scan_reg = 5'd4;
        scan_en  = 1'b1;
        n0 = fr_n;
        wait_frames(n0 + 4);
        repeat (2 * DIVH + 2) @(negedge clk);
        chk(changed == 0 && !irq, "R10", "no change no flag", changed, 0);
        chk(fr_phy[n0] != fr_phy[n0 + 1] && fr_reg[n0] == 4, "R10", "round robin",
            {fr_phy[n0], fr_phy[n0+1]}, {5'd3, 5'd17});

        // R10: injected change
        phy_regs[17][4] = 16'hBEEF;
        n0 = fr_n;
        wait_frames(n0 + 3);
        repeat (2 * DIVH + 2) @(negedge clk);
        chk(changed == (32'd1 << 17), "R10", "changed bit", changed, 32'd1 << 17);
        chk(irq, "R11", "irq on change", irq, 1);
        host_rd(17, v);
        chk(v == 32'h0000_BEEF, "R10", "shadow updated", v, 32'hBEEF);

        // R12: command wins at boundary
        phy_regs[20][1] = 16'h5A5A;
        issue(2'd0, 20, 1, 16'h0);
        n0 = fr_n;
        wait_frames(n0 + 1);
        chk(fr_phy[n0] == 20 && fr_op[n0] == 2'b10, "R12", "command frame first", fr_phy[n0], 20);
        repeat (2 * DIVH + 2) @(negedge clk);
        chk(rd_data == 16'h5A5A, "R3", "read during scan", rd_data, 16'h5A5A);

        // R11: write-one-to-clear
        @(negedge clk);
        chg_clr = 32'd1 << 17;
        @(negedge clk);
        chg_clr = '0;
        chk(changed == 0 && !irq, "R11", "clear", changed, 0);
        n0 = fr_n;
        wait_frames(n0 + 4);
        repeat (2 * DIVH + 2) @(negedge clk);
        chk(changed == 0, "R10", "stays clear", changed, 0);

        scan_en = 1'b0;
        wait_idle();
        chk(!mdc && !mdio_oe, "R4", "idle after scan", {mdc, mdio_oe}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule